// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Programmable Bit Rate

This block is a small asynchronous serial port that sits on a simple 32-bit register bus and drives a transmit pin and samples a receive pin directly. Software sets the bit time through a divider register and moves bytes through a single data register. Writing the data register sends one byte framed as eight data bits with no parity and one stop bit. Reading the data register hands back the most recently received byte.

The port has no status register. An empty receive buffer is shown in the read value itself: a read with nothing waiting returns all 32 bits set, which can never be a zero-extended byte. The transmitter has no queue. A second data write issued while a byte is still going out is held off by keeping the bus ready low until the line is free, so software never loses a byte.

The receiver runs the input through two flip-flops. It waits for a falling edge and confirms the start bit half a bit time later. It then samples each data bit and the stop bit in the middle of its bit time. Only a frame whose stop bit is high is kept.

Top module: `sio_uart`

## Requirements
- R1: After reset the transmit pin is high. The divider reads back its reset default (16). A read of the data register returns 0xFFFFFFFF.
- R2: The divider register is at byte offset 0x4. A write stores the low DIV_W bits of the write data, and a read returns that value with the upper bits zero.
- R3: One bit time on both pins lasts max(divider, 2) clock cycles, so divider values 0 and 1 behave as 2.
- R4: A data write at offset 0x8 sends one frame, least significant bit first: a low start bit, then bits 7:0 of the write data, then a high stop bit. The pin goes low on the clock edge that accepts the write, and it stays high whenever no frame is being sent.
- R5: A data write that arrives while a frame is being sent keeps bus_ready low until the transmitter is idle, then completes. Counted from the edge that accepted the previous write, the stall lasts exactly 10 bit times.
- R6: The receiver looks for a falling edge after its two-flop input synchronizer and confirms the start bit half a bit time later. A low pulse shorter than that is ignored. Each data bit and the stop bit are sampled one bit time apart. A frame whose stop bit is low is dropped.
- R7: A data register read with a byte waiting returns the byte in bits 7:0 with zeros above, and empties the buffer.
- R8: A data register read with no byte waiting returns 0xFFFFFFFF.
- R9: A newly received byte replaces an unread one. The next read returns the newer byte.
- R10: Reads at any offset other than 0x4 and 0x8 return zero, and writes there change nothing. Reads and divider writes never stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request present |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_valid is high |
| bus_ready | output | 1 | Request completes on this edge when high |
| uart_txd | output | 1 | Serial transmit pin, idle high |
| uart_rxd | input | 1 | Serial receive pin, asynchronous |

## Verification
On every cycle the assertions check the following:
- the transmit line is high when the transmitter is idle;
- the line holds steady inside a bit time;
- a start bit follows every accepted write;
- a blocked data write keeps ready low;
- a data read drains the buffer;
- a fresh byte always lands in the buffer;
- a received byte is only delivered after a high stop bit.

Only the bench scenarios can show whole-frame properties. These include:
- the bit order and value of each frame at several divider settings;
- the exact length of the stall;
- the clamping of small dividers;
- the byte returned through loopback;
- overwrite and empty-read values;
- rejection of a short start glitch and of a frame with a low stop bit.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned OFF_DIV  = 4;
  localparam int unsigned OFF_DATA = 8;
  localparam int unsigned MIN_BIT  = 2;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // clock cycles in one bit time for a given divider value
  function automatic logic [31:0] bit_cycles(input logic [31:0] div);
    return (div < MIN_BIT) ? 32'(MIN_BIT) : div;
  endfunction

  // delay from start edge to mid start bit
  function automatic logic [31:0] half_cycles(input logic [31:0] div);
    return bit_cycles(div) >> 1;
  endfunction

  // shift pattern for one frame: stop, data, start (bit 0 goes out first)
  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  output logic             txd_o,
  output logic             busy_o
);
  import sio_pkg::*;

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      left_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [31:0]           full32;
  logic [DIV_W-1:0]      reload;
  logic                  bit_end;

  assign full32  = bit_cycles(32'(div_i));
  assign reload  = DIV_W'(full32 - 32'd1);
  assign busy_o  = (left_q != '0);
  assign bit_end = busy_o && (cnt_q == '0);
  assign txd_o   = busy_o ? shift_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
    end else if (start_i && !busy_o) begin
      shift_q <= frame_of(data_i);
      left_q  <= CNT_W'(FRAME_BITS);
      cnt_q   <= reload;
    end else if (bit_end) begin
      shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
      left_q  <= left_q - 1'b1;
      cnt_q   <= reload;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (!txd_o && busy_o));
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q != '0 && !start_i) |=> $stable(txd_o));

endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic [7:0]       byte_o
);
  import sio_pkg::*;

  rx_state_e        st_q;
  logic [1:0]       sync_q;
  logic             rx_s;
  logic             prev_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       nbit_q;
  logic [7:0]       sh_q;
  logic             done_q;
  logic [7:0]       byte_q;
  logic [31:0]      full32;
  logic [31:0]      half32;
  logic [DIV_W-1:0] full_ld;
  logic [DIV_W-1:0] half_ld;
  logic             fall_evt;
  logic             sample_tick;

  assign rx_s        = sync_q[1];
  assign full32      = bit_cycles(32'(div_i));
  assign half32      = half_cycles(32'(div_i));
  assign full_ld     = DIV_W'(full32 - 32'd1);
  assign half_ld     = DIV_W'(half32 - 32'd1);
  assign fall_evt    = prev_q && !rx_s;
  assign sample_tick = (st_q != RX_IDLE) && (cnt_q == '0);
  assign done_o      = done_q;
  assign byte_o      = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      byte_q <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= rx_s;
      done_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (fall_evt) begin
            cnt_q <= half_ld;
            st_q  <= RX_START;
          end
        end
        RX_START: begin
          if (!sample_tick) cnt_q <= cnt_q - 1'b1;
          else if (!rx_s) begin
            cnt_q  <= full_ld;
            nbit_q <= '0;
            st_q   <= RX_DATA;
          end else st_q <= RX_IDLE;
        end
        RX_DATA: begin
          if (!sample_tick) cnt_q <= cnt_q - 1'b1;
          else begin
            sh_q  <= {rx_s, sh_q[7:1]};
            cnt_q <= full_ld;
            if (nbit_q == 3'd7) st_q <= RX_STOP;
            else nbit_q <= nbit_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (!sample_tick) cnt_q <= cnt_q - 1'b1;
          else begin
            if (rx_s) begin
              done_q <= 1'b1;
              byte_q <= sh_q;
            end
            st_q <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rx_s));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/sio_regs.sv
module sio_regs #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic              tx_busy_i,
  input  logic              rx_done_i,
  input  logic [7:0]        rx_byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              tx_start_o,
  output logic [7:0]        tx_data_o
);
  import sio_pkg::*;

  logic             hit_div;
  logic             hit_data;
  logic             data_wr;
  logic             fire;
  logic             rd_data;
  logic [DIV_W-1:0] div_q;
  logic             buf_v_q;
  logic [7:0]       buf_q;

  assign hit_div    = (bus_addr == ADDR_W'(OFF_DIV));
  assign hit_data   = (bus_addr == ADDR_W'(OFF_DATA));
  assign data_wr    = bus_valid && bus_we && hit_data;
  assign bus_ready  = !(data_wr && tx_busy_i);
  assign fire       = bus_valid && bus_ready;
  assign tx_start_o = fire && bus_we && hit_data;
  assign tx_data_o  = bus_wdata[7:0];
  assign rd_data    = fire && !bus_we && hit_data;
  assign div_o      = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RST);
      buf_v_q <= 1'b0;
      buf_q   <= '0;
    end else begin
      if (fire && bus_we && hit_div) div_q <= bus_wdata[DIV_W-1:0];
      if (rx_done_i) begin
        buf_v_q <= 1'b1;
        buf_q   <= rx_byte_i;
      end else if (rd_data) begin
        buf_v_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (hit_div)       bus_rdata = 32'(div_q);
    else if (hit_data) bus_rdata = buf_v_q ? {24'd0, buf_q} : '1;
    else               bus_rdata = '0;
  end

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_busy_i) |-> (!bus_ready && !tx_start_o));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done_i) |=> !buf_v_q);
  p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> (buf_v_q && buf_q == $past(rx_byte_i)));

endmodule

// File: rtl/sio_uart.sv
module sio_uart #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              uart_txd,
  input  logic              uart_rxd
);

  logic [DIV_W-1:0] div_w;
  logic             tx_start_w;
  logic [7:0]       tx_data_w;
  logic             tx_busy_w;
  logic             rx_done_w;
  logic [7:0]       rx_byte_w;

  sio_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .tx_busy_i  (tx_busy_w),
    .rx_done_i  (rx_done_w),
    .rx_byte_i  (rx_byte_w),
    .div_o      (div_w),
    .tx_start_o (tx_start_w),
    .tx_data_o  (tx_data_w)
  );

  sio_tx #(.DIV_W(DIV_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_i   (div_w),
    .start_i (tx_start_w),
    .data_i  (tx_data_w),
    .txd_o   (uart_txd),
    .busy_o  (tx_busy_w)
  );

  sio_rx #(.DIV_W(DIV_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div_w),
    .rxd_i  (uart_rxd),
    .done_o (rx_done_w),
    .byte_o (rx_byte_w)
  );

endmodule

// File: tb/test_sio_uart.sv
`timescale 1ns/1ps
module test_sio_uart;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        uart_txd;
  logic        drv_rxd = 1'b1;
  logic        loop_en = 1'b0;
  logic        uart_rxd;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign uart_rxd = loop_en ? uart_txd : drv_rxd;

  sio_uart i_sio_uart (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .uart_txd(uart_txd), .uart_rxd(uart_rxd)
  );

  // divider, byte
  localparam logic [23:0] VEC [0:5] = '{
    24'h0004_A5, 24'h0005_3C, 24'h0008_00,
    24'h0002_FF, 24'h0003_81, 24'h0007_5E
  };

  function automatic int eff(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int stalls;

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    stalls = 0;
    #1;
    while (!bus_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int bt);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      drv_rxd = f[k];
      repeat (bt - 1) @(negedge clk);
    end
    @(negedge clk);
    drv_rxd = 1'b1;
    repeat (2 * bt + 6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [9:0]  got, exp_f;
    int d, bt;

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 txd idle", {31'd0, uart_txd}, 32'd1);
    rst_n = 1'b1;
    bus_read(4'h4, rd); chk("R1 divider default", rd, 32'd16);
    bus_read(4'h8, rd); chk("R1 empty data", rd, 32'hFFFFFFFF);

    // table walk: R2 R3 R4 R7 R8 through loopback
    loop_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      d  = int'(VEC[i][23:8]);
      bt = eff(d);
      bus_write(4'h4, {16'hABCD, VEC[i][23:8]});
      bus_read(4'h4, rd); chk("R2 divider readback", rd, {16'd0, VEC[i][23:8]});
      bus_write(4'h8, {24'hFFFFFF, VEC[i][7:0]});
      exp_f = {1'b1, VEC[i][7:0], 1'b0};
      repeat (bt / 2) @(posedge clk);
      #1;
      got[0] = uart_txd;
      for (int k = 1; k < 10; k++) begin
        repeat (bt) @(posedge clk);
        #1;
        got[k] = uart_txd;
      end
      chk("R4 frame bits", {22'd0, got}, {22'd0, exp_f});
      repeat (2 * bt + 8) @(posedge clk);
      #1;
      chk("R4 idle high after frame", {31'd0, uart_txd}, 32'd1);
      bus_read(4'h8, rd); chk("R7 loopback byte", rd, {24'd0, VEC[i][7:0]});
      bus_read(4'h8, rd); chk("R8 drained read", rd, 32'hFFFFFFFF);
    end
    loop_en = 1'b0;

    // R5 stall length, R3 clamp of divider 0 and 1
    bus_write(4'h4, 32'd6);
    bus_write(4'h8, 32'h11);
    bus_write(4'h8, 32'h22);
    chk("R5 stall cycles div6", stalls, 32'd60);
    repeat (70) @(posedge clk);
    bus_write(4'h4, 32'd0);
    bus_read(4'h4, rd); chk("R2 divider zero", rd, 32'd0);
    bus_write(4'h8, 32'h33);
    bus_write(4'h8, 32'h44);
    chk("R3 clamp div0 stall", stalls, 32'd20);
    repeat (30) @(posedge clk);
    bus_write(4'h4, 32'd1);
    bus_write(4'h8, 32'h55);
    bus_write(4'h8, 32'h66);
    chk("R3 clamp div1 stall", stalls, 32'd20);
    repeat (30) @(posedge clk);
    // R10 reads and divider writes do not stall even while busy
    bus_write(4'h8, 32'h77);
    bus_read(4'h8, rd);
    bus_write(4'h4, 32'd8);
    chk("R10 divider write no stall", stalls, 32'd0);
    repeat (40) @(posedge clk);

    // R9 overwrite with manual rx at divider 8
    bus_read(4'h8, rd);
    send_frame(8'h5A, 1'b1, 8);
    send_frame(8'hC3, 1'b1, 8);
    bus_read(4'h8, rd); chk("R9 newest byte kept", rd, 32'h000000C3);
    bus_read(4'h8, rd); chk("R9 buffer empty after", rd, 32'hFFFFFFFF);

    // R6 low stop bit drops the frame
    send_frame(8'h96, 1'b0, 8);
    bus_read(4'h8, rd); chk("R6 framing error dropped", rd, 32'hFFFFFFFF);

    // R6 glitch shorter than half a bit ignored
    @(negedge clk); drv_rxd = 1'b0;
    repeat (2) @(negedge clk); drv_rxd = 1'b1;
    repeat (120) @(negedge clk);
    bus_read(4'h8, rd); chk("R6 short glitch ignored", rd, 32'hFFFFFFFF);
    send_frame(8'h0F, 1'b1, 8);
    bus_read(4'h8, rd); chk("R6 frame after glitch", rd, 32'h0000000F);

    // R10 unmapped offsets
    bus_write(4'hC, 32'd3);
    bus_read(4'hC, rd); chk("R10 unmapped read 0xC", rd, 32'd0);
    bus_read(4'h0, rd); chk("R10 unmapped read 0x0", rd, 32'd0);
    bus_read(4'h4, rd); chk("R10 unmapped write ignored", rd, 32'd8);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule